// File: doc/BRIEF.md
# Flash Write-Status Flag Generator

This block forms the byte a NOR-style flash puts on its data pins when the host reads it while an embedded program or erase is running. The host polls this byte to learn whether the internal algorithm is still busy, whether it ran past its time limit, and which sector is being erased. The command decoder supplies the operation mode and one strobe per command write pulse. The algorithm sequencer supplies completion and timeout flags. Each host read supplies a one-cycle read strobe, a flag saying whether the address falls in the sector under erase (or suspended erase), and the array byte at that address.

The output byte is registered on each read strobe and holds between reads. Two toggle bits (bit 6 and bit 2) flip on each qualifying read. Status only replaces array data once the command's last write pulse has arrived: the 4th pulse for a program, the 6th for an erase.

Top module: `flash_status_gen`

## Requirements
- R1: While reset is low, `dq_out` is 8'h00, and both toggle states are cleared.
- R2: In mode 0 (read), and in modes 1 (program) and 2 (erase) before their command has received 4 or 6 `cmd_wr` pulses respectively since the last `op_start`, a read returns `array_data` unchanged.
- R3: During a running program (mode 1, not done), bit 7 is the inverse of `last_data[7]`, bit 3 is 0 and bit 2 is 1.
- R4: During a running erase (mode 2, not done), bit 7 is 0 and bit 3 is 1.
- R5: During a running program or erase, bit 6 returns the toggle state, which starts at 0 after `op_start` and inverts after every status read at any address.
- R6: During a running erase, bit 2 returns a second toggle state that inverts only after reads with `rd_in_sector` high, and holds after reads outside the sector.
- R7: Bit 5 equals `timeout` on every status read of a running operation; bits 7 and 6 behave as in R3 to R5 whatever `timeout` is.
- R8: With `alg_done` high, a read returns bit 7 = `last_data[7]` (program, mode 1 or 4) or 1 (erase, mode 2), with bits 6..0 from `array_data`, and no toggle advances.
- R9: In erase-suspend (mode 3), an in-sector read returns bit 7 = 1, bit 6 the held toggle state (not advancing) and bit 2 the toggling state; a read outside the sector returns `array_data`.
- R10: In program-during-suspend (mode 4, armed after 4 pulses), bit 7 is the inverse of `last_data[7]`, bit 6 toggles on every read, and bit 2 toggles on in-sector reads and reads 1 elsewhere.
- R11: Whenever a status byte is returned, bits 4, 1 and 0 are 0.
- R12: `dq_out` keeps its value in every cycle without `rd_strobe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_start | input | 1 | New command begins: clears pulse count and toggles |
| mode_sel | input | 3 | 0 read, 1 program, 2 erase, 3 erase-suspend, 4 program in suspend |
| cmd_wr | input | 1 | One command write pulse (one cycle) |
| alg_done | input | 1 | Embedded algorithm finished |
| timeout | input | 1 | Algorithm exceeded its time limit |
| last_data | input | 8 | Data byte being programmed |
| rd_strobe | input | 1 | One-cycle host read |
| rd_in_sector | input | 1 | Read address lies in the erased or suspended sector |
| array_data | input | 8 | Array byte at the read address |
| dq_out | output | 8 | Byte returned to the host |

## Verification
The assertions assume `op_start` and `cmd_wr` never share a cycle, that `rd_strobe` lasts a single cycle, and that `mode_sel` stays in 0 to 4 and is stable around each read. The stimulus changes mode, data and sector flags only in cycles without a read strobe, issues every command as separate one-cycle pulses, and moves into erase-suspend without a new `op_start` so the erase's pulse count carries over.

// File: rtl/flash_status_pkg.sv
// Shared types for the flash write-status generator.
// Assumes an 8-bit status byte; bit positions are fixed by the host polling protocol.
package flash_status_pkg;
    localparam int STAT_W = 8;

    typedef enum logic [2:0] {
        FM_READ       = 3'd0,
        FM_PROG       = 3'd1,
        FM_ERASE      = 3'd2,
        FM_ESUSP      = 3'd3,
        FM_ESUSP_PROG = 3'd4
    } fmode_t;
endpackage

// File: rtl/fst_cmd_window.sv
// Counts command write pulses since op_start and raises armed once the
// command's final pulse has arrived. Assumes op_start and cmd_wr are not
// asserted together; the count saturates at the larger threshold.
module fst_cmd_window #(
    parameter int PROG_PULSES  = 4,
    parameter int ERASE_PULSES = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic op_start,
    input  logic cmd_wr,
    input  logic need_erase,
    output logic armed
);
    localparam int MAXP  = (ERASE_PULSES > PROG_PULSES) ? ERASE_PULSES : PROG_PULSES;
    localparam int CNT_W = $clog2(MAXP + 1);

    logic [CNT_W-1:0] pulse_cnt;

    // Pulse counter: clear on a new command, saturate at the largest threshold.
    always_ff @(posedge clk) begin
        if (!rst_n || op_start) begin
            pulse_cnt <= '0;
        end else if (cmd_wr && (pulse_cnt < CNT_W'(MAXP))) begin
            pulse_cnt <= pulse_cnt + 1'b1;
        end
    end

    // Threshold compare selected by the operation type.
    always_comb begin
        if (need_erase) armed = (pulse_cnt >= CNT_W'(ERASE_PULSES));
        else            armed = (pulse_cnt >= CNT_W'(PROG_PULSES));
    end
endmodule

// File: rtl/fst_toggle_bank.sv
// Bank of read-driven toggle states. Each entry inverts on a cycle where its
// advance request is high; all entries clear on clr. Assumes advance requests
// are already qualified by the read strobe.
module fst_toggle_bank #(
    parameter int NTOG = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic [NTOG-1:0] adv,
    output logic [NTOG-1:0] tog
);
    for (genvar gi = 0; gi < NTOG; gi++) begin : g_tog
        // One toggle flop: clear on reset or new operation, invert on advance.
        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                tog[gi] <= 1'b0;
            end else if (adv[gi]) begin
                tog[gi] <= ~tog[gi];
            end
        end
    end
endmodule

// File: rtl/fst_status_mux.sv
// Combinational status assembly. Chooses between array data, completion data
// and the status byte per mode, and says which toggle states the current read
// would advance. Assumes mode values outside the enum behave as plain reads.
module fst_status_mux
    import flash_status_pkg::*;
(
    input  fmode_t             mode,
    input  logic               armed,
    input  logic               done,
    input  logic               timeout,
    input  logic               last_d7,
    input  logic               in_sector,
    input  logic               tog6,
    input  logic               tog2,
    input  logic [STAT_W-1:0]  array_data,
    output logic [STAT_W-1:0]  status,
    output logic               adv6,
    output logic               adv2,
    output logic               stat_act
);
    // Per-mode selection of the returned byte and toggle advance requests.
    always_comb begin
        status   = array_data;
        adv6     = 1'b0;
        adv2     = 1'b0;
        stat_act = 1'b0;
        unique case (mode)
            FM_PROG: begin
                if (armed && done) begin
                    status = {last_d7, array_data[6:0]};
                end else if (armed) begin
                    status   = {~last_d7, tog6, timeout, 1'b0, 1'b0, 1'b1, 2'b00};
                    adv6     = 1'b1;
                    stat_act = 1'b1;
                end
            end
            FM_ERASE: begin
                if (armed && done) begin
                    status = {1'b1, array_data[6:0]};
                end else if (armed) begin
                    status   = {1'b0, tog6, timeout, 1'b0, 1'b1, tog2, 2'b00};
                    adv6     = 1'b1;
                    adv2     = in_sector;
                    stat_act = 1'b1;
                end
            end
            FM_ESUSP: begin
                if (armed && in_sector) begin
                    status   = {1'b1, tog6, 1'b0, 1'b0, 1'b0, tog2, 2'b00};
                    adv2     = 1'b1;
                    stat_act = 1'b1;
                end
            end
            FM_ESUSP_PROG: begin
                if (armed && done) begin
                    status = {last_d7, array_data[6:0]};
                end else if (armed) begin
                    status   = {~last_d7, tog6, timeout, 1'b0, 1'b0,
                                (in_sector ? tog2 : 1'b1), 2'b00};
                    adv6     = 1'b1;
                    adv2     = in_sector;
                    stat_act = 1'b1;
                end
            end
            default: begin
                status = array_data;
            end
        endcase
    end
endmodule

// File: rtl/flash_status_gen.sv
// Top of the write-status generator. Registers the byte returned to the host
// on each read strobe and advances the toggle states on the same edge.
// Assumes rd_strobe is one cycle per host read and mode_sel is stable around it.
module flash_status_gen
    import flash_status_pkg::*;
#(
    parameter int PROG_PULSES  = 4,
    parameter int ERASE_PULSES = 6
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        op_start,
    input  logic [2:0]  mode_sel,
    input  logic        cmd_wr,
    input  logic        alg_done,
    input  logic        timeout,
    input  logic [7:0]  last_data,
    input  logic        rd_strobe,
    input  logic        rd_in_sector,
    input  logic [7:0]  array_data,
    output logic [7:0]  dq_out
);
    localparam int NTOG = 2;

    fmode_t            mode;
    logic              armed;
    logic              need_erase;
    logic [NTOG-1:0]   tog;
    logic [NTOG-1:0]   adv_q;
    logic              adv6;
    logic              adv2;
    logic              stat_act;
    logic [STAT_W-1:0] status;

    // Mode decode: erase-type modes wait for the longer command.
    always_comb begin
        mode       = fmode_t'(mode_sel);
        need_erase = (mode == FM_ERASE) || (mode == FM_ESUSP);
    end

    fst_cmd_window #(
        .PROG_PULSES  (PROG_PULSES),
        .ERASE_PULSES (ERASE_PULSES)
    ) u_window (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_start   (op_start),
        .cmd_wr     (cmd_wr),
        .need_erase (need_erase),
        .armed      (armed)
    );

    fst_status_mux u_mux (
        .mode       (mode),
        .armed      (armed),
        .done       (alg_done),
        .timeout    (timeout),
        .last_d7    (last_data[7]),
        .in_sector  (rd_in_sector),
        .tog6       (tog[1]),
        .tog2       (tog[0]),
        .array_data (array_data),
        .status     (status),
        .adv6       (adv6),
        .adv2       (adv2),
        .stat_act   (stat_act)
    );

    // Qualify toggle advances with the read strobe.
    always_comb begin
        adv_q = {adv6 & rd_strobe, adv2 & rd_strobe};
    end

    fst_toggle_bank #(
        .NTOG (NTOG)
    ) u_tog (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (op_start),
        .adv   (adv_q),
        .tog   (tog)
    );

    // Output register: capture the selected byte on each host read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dq_out <= '0;
        end else if (rd_strobe) begin
            dq_out <= status;
        end
    end
endmodule

// File: rtl/flash_status_gen_chk.sv
// Property checker for flash_status_gen, attached by bind. Observes ports and
// the toggle and mux signals that separate submodules drive.
module flash_status_gen_chk (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       op_start,
    input  logic [2:0] mode_sel,
    input  logic       alg_done,
    input  logic       timeout,
    input  logic [7:0] last_data,
    input  logic       rd_strobe,
    input  logic       armed,
    input  logic       tog6,
    input  logic       adv6,
    input  logic       stat_act,
    input  logic [7:0] dq_out
);
    // R1
    rst_clear_chk: assert property (@(posedge clk)
        !rst_n |=> dq_out == 8'h00);

    // R12
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_strobe |=> $stable(dq_out));

    // R3
    prog_poll_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && mode_sel == 3'd1 && armed && !alg_done)
        |=> (dq_out[7] != $past(last_data[7])) && (dq_out[3:2] == 2'b01));

    // R4
    erase_poll_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && mode_sel == 3'd2 && armed && !alg_done)
        |=> (dq_out[7] == 1'b0) && (dq_out[3] == 1'b1));

    // R5
    dq6_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && adv6 && !op_start) |=> tog6 != $past(tog6));

    // R9
    susp_hold6_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && mode_sel == 3'd3 && !op_start) |=> $stable(tog6));

    // R11
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && stat_act) |=> (dq_out[4] == 1'b0) && (dq_out[1:0] == 2'b00));

    // R7
    timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && stat_act && mode_sel != 3'd3) |=> dq_out[5] == $past(timeout));
endmodule

bind flash_status_gen flash_status_gen_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_start  (op_start),
    .mode_sel  (mode_sel),
    .alg_done  (alg_done),
    .timeout   (timeout),
    .last_data (last_data),
    .rd_strobe (rd_strobe),
    .armed     (armed),
    .tog6      (tog[1]),
    .adv6      (adv6),
    .stat_act  (stat_act),
    .dq_out    (dq_out)
);

// File: tb/tb_flash_status_gen.sv
// Scoreboard bench: the read task queues the expected byte, a monitor pops and
// compares once the output register has captured the read.
module tb_flash_status_gen;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_start = 1'b0;
    logic [2:0] mode_sel = 3'd0;
    logic       cmd_wr = 1'b0;
    logic       alg_done = 1'b0;
    logic       timeout = 1'b0;
    logic [7:0] last_data = 8'h00;
    logic       rd_strobe = 1'b0;
    logic       rd_in_sector = 1'b0;
    logic [7:0] array_data = 8'h3C;
    logic [7:0] dq_out;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;
    logic [7:0] expq[$];
    string      tagq[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_status_gen dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .op_start     (op_start),
        .mode_sel     (mode_sel),
        .cmd_wr       (cmd_wr),
        .alg_done     (alg_done),
        .timeout      (timeout),
        .last_data    (last_data),
        .rd_strobe    (rd_strobe),
        .rd_in_sector (rd_in_sector),
        .array_data   (array_data),
        .dq_out       (dq_out)
    );

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic start_op(input logic [2:0] m);
        @(negedge clk);
        mode_sel = m;
        op_start = 1'b1;
        @(negedge clk);
        op_start = 1'b0;
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cmd_wr = 1'b1;
            @(negedge clk);
            cmd_wr = 1'b0;
        end
    endtask

    // Driver: queue the expected byte and issue one read.
    task automatic rd(input logic in_sec, input logic [7:0] exp, input string tag);
        @(negedge clk);
        rd_in_sector = in_sec;
        expq.push_back(exp);
        tagq.push_back(tag);
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
    endtask

    // Monitor: after each strobed edge, compare the captured byte.
    initial begin
        forever begin
            @(posedge clk);
            if (rd_strobe === 1'b1) begin
                #1;
                if (expq.size() > 0) begin
                    check(dq_out, expq.pop_front(), tagq.pop_front());
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        idle(3);
        check(dq_out, 8'h00, "R1 reset");
        rst_n = 1'b1;
        idle(1);

        // Plain read mode passes array data through.
        array_data = 8'h5A;
        rd(1'b0, 8'h5A, "R2 read mode");
        array_data = 8'h3C;

        // Program: 0xA5, so bit 7 polls as 0 until done.
        last_data = 8'hA5;
        start_op(3'd1);
        pulses(2);
        rd(1'b1, 8'h3C, "R2 program not armed");
        pulses(2);
        rd(1'b1, 8'h04, "R3 R11 program status");
        rd(1'b0, 8'h44, "R5 dq6 second read");
        timeout = 1'b1;
        rd(1'b1, 8'h24, "R7 timeout set");
        timeout = 1'b0;
        idle(4);
        check(dq_out, 8'h24, "R12 hold without read");
        alg_done = 1'b1;
        rd(1'b1, 8'hBC, "R8 program done");
        alg_done = 1'b0;

        // Erase: armed only after the 6th pulse.
        start_op(3'd2);
        pulses(5);
        rd(1'b1, 8'h3C, "R2 erase not armed");
        pulses(1);
        rd(1'b1, 8'h08, "R4 erase in sector");
        rd(1'b0, 8'h4C, "R6 erase outside sector holds dq2");
        rd(1'b1, 8'h0C, "R6 erase in sector toggles dq2");

        // Erase-suspend, count carried over from the erase.
        mode_sel = 3'd3;
        rd(1'b1, 8'hC0, "R9 suspend in sector");
        rd(1'b1, 8'hC4, "R9 suspend dq6 held dq2 toggles");
        rd(1'b0, 8'h3C, "R9 suspend outside sector");

        // Erase completion.
        mode_sel = 3'd2;
        alg_done = 1'b1;
        array_data = 8'h11;
        rd(1'b1, 8'h91, "R8 erase done");
        alg_done = 1'b0;
        array_data = 8'h3C;

        // Program during erase-suspend, data 0x00.
        last_data = 8'h00;
        start_op(3'd4);
        pulses(4);
        rd(1'b0, 8'h84, "R10 suspend program outside");
        rd(1'b1, 8'hC0, "R10 suspend program in sector");
        rd(1'b1, 8'h84, "R10 suspend program dq2 toggled");

        idle(3);
        if (expq.size() != 0) begin
            total++;
            bad++;
            $display("FAIL scoreboard: got %0d pending expected 0", expq.size());
        end
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule